// File: doc/BRIEF.md
# Raster Display Timing and Interrupt Generator

This block produces the horizontal and vertical timing of a raster display from one shared chain of counters. A prescaler turns a dot-clock enable into dot ticks. A dot counter splits each scanline into an active part followed by a blanking part. A line counter walks the frame, which has a visible region followed by a vertical blanking region. From these counters the block keeps a horizontal-blank flag and a vertical-blank flag, a frame-swap strobe, and the current line number.

Two processors observe the same timing. Each one owns a separate register copy that holds three interrupt enables and a compare line. Each copy keeps its own line-match flag and sends its own one-cycle interrupt pulses for horizontal blank, vertical blank and line match. The blank flags are common to both copies, so they always change together. Each copy's registers are loaded through its own write strobe.

Top module: `disp_timing_gen`

## Requirements
- R1: The dot position advances by one only on a cycle where `dot_en_i` is high, and only once every CYC_PER_DOT such cycles. While `dot_en_i` is low, no flag, line or pulse changes. A line lasts ACTIVE_DOTS plus BLANK_DOTS dots.
- R2: `line_o` counts from 0 to LINES-1 and then wraps to 0. It advances on the dot tick that ends a line's last blanking dot.
- R3: On the tick that ends the last active dot of any line (vertical-blank lines included), `hblank_o` goes high. In that same cycle, every copy whose enable bit 1 is set pulses its irq bit 1.
- R4: `hblank_o` goes low in the cycle that `line_o` advances.
- R5: On advancing into line VIS_LINES, three things happen in the same cycle: `swap_o` pulses, `vblank_o` goes high, and every copy whose enable bit 0 is set pulses its irq bit 0.
- R6: `vblank_o` goes low on advancing into line LINES-1, one line before the wrap.
- R7: At every line advance, each copy sets its bit of `match_o` to whether the new line equals that copy's compare value. If they are equal and the copy's enable bit 2 is set, the copy pulses its irq bit 2.
- R8: Each copy has a 3-bit field of `irq_o`: bit 0 is vertical blank, bit 1 is horizontal blank and bit 2 is line match. Copy c uses bits 3c to 3c+2. Every pulse lasts exactly one clock cycle.
- R9: A write to copy c (`wr_en_i[c]`) loads that copy's enables from `wr_irq_en_i[3c+2:3c]` and its compare value from `wr_cmp_i`, and leaves the other copy untouched. The new values apply from the next cycle on. An advance in the same cycle as the write still compares against the old value.
- R10: After reset, `line_o` is 0 and the dot position is 0. All flags, enables, compare values and pulses are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dot_en_i | input | 1 | Dot-clock enable |
| wr_en_i | input | NUM_CPU | Per-copy register write strobe |
| wr_irq_en_i | input | 3*NUM_CPU | Interrupt enables for each copy (bit 0 vblank, bit 1 hblank, bit 2 match) |
| wr_cmp_i | input | LINE_W*NUM_CPU | Compare line for each copy |
| hblank_o | output | 1 | Horizontal-blank flag |
| vblank_o | output | 1 | Vertical-blank flag |
| match_o | output | NUM_CPU | Per-copy line-match flag |
| line_o | output | LINE_W | Current line number |
| swap_o | output | 1 | Frame-swap strobe |
| irq_o | output | 3*NUM_CPU | Per-copy interrupt pulses |

## Verification
The bench builds the block with a shrunken frame: 8 active and 5 blanking dots, 12 lines of which 7 are visible, and 2 cycles per dot. A whole frame then takes a few hundred cycles, so the run covers many wraps, vertical-blank entries and exits, and the vertical-blank-end line. It also reaches compare values at line 0, at the first blank line and at the last line, and writes that land on the same cycle as a line advance. The random, gapped dot enable checks that the prescaler holds still between enabled cycles.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int unsigned IRQ_W     = 3;
  localparam int unsigned IRQ_VBL   = 0;
  localparam int unsigned IRQ_HBL   = 1;
  localparam int unsigned IRQ_MATCH = 2;
endpackage

// File: rtl/disp_dot_timer.sv
module disp_dot_timer #(
  parameter int unsigned ACTIVE_DOTS = 256,
  parameter int unsigned BLANK_DOTS  = 99,
  parameter int unsigned CYC_PER_DOT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dot_en_i,
  output logic hdraw_end_o,
  output logic line_end_o
);
  localparam int unsigned TOTAL  = ACTIVE_DOTS + BLANK_DOTS;
  localparam int unsigned DOT_W  = $clog2(TOTAL);
  localparam int unsigned PRE_W  = (CYC_PER_DOT > 1) ? $clog2(CYC_PER_DOT) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CYC_PER_DOT - 1);
  localparam logic [DOT_W-1:0] DOT_LAST = DOT_W'(TOTAL - 1);
  localparam logic [DOT_W-1:0] ACT_LAST = DOT_W'(ACTIVE_DOTS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [DOT_W-1:0] dot_q;
  logic             tick;

  assign tick        = dot_en_i && (pre_q == PRE_MAX);
  assign hdraw_end_o = tick && (dot_q == ACT_LAST);
  assign line_end_o  = tick && (dot_q == DOT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      dot_q <= '0;
    end else if (dot_en_i) begin
      pre_q <= (pre_q == PRE_MAX) ? '0 : pre_q + 1'b1;
      if (tick) dot_q <= (dot_q == DOT_LAST) ? '0 : dot_q + 1'b1;
    end
  end

  // R1
  dot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_q <= DOT_LAST);
  // R1
  dot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dot_en_i |=> $stable(dot_q) && $stable(pre_q));
endmodule

// File: rtl/disp_line_ctr.sv
module disp_line_ctr #(
  parameter int unsigned LINES     = 263,
  parameter int unsigned VIS_LINES = 192,
  parameter int unsigned LINE_W    = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdraw_end_i,
  input  logic              line_end_i,
  output logic [LINE_W-1:0] line_o,
  output logic [LINE_W-1:0] line_next_o,
  output logic              vbl_evt_o,
  output logic              hblank_o,
  output logic              vblank_o,
  output logic              swap_o
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);
  localparam logic [LINE_W-1:0] VBL_LINE  = LINE_W'(VIS_LINES);

  logic [LINE_W-1:0] line_q;
  logic              hbl_q, vbl_q, swap_q;

  assign line_next_o = (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
  assign vbl_evt_o   = line_end_i && (line_next_o == VBL_LINE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      hbl_q  <= 1'b0;
      vbl_q  <= 1'b0;
      swap_q <= 1'b0;
    end else begin
      swap_q <= vbl_evt_o;
      if (hdraw_end_i) hbl_q <= 1'b1;
      if (line_end_i) begin
        line_q <= line_next_o;
        hbl_q  <= 1'b0;
        if (line_next_o == VBL_LINE)       vbl_q <= 1'b1;
        else if (line_next_o == LAST_LINE) vbl_q <= 1'b0;
      end
    end
  end

  assign line_o   = line_q;
  assign hblank_o = hbl_q;
  assign vblank_o = vbl_q;
  assign swap_o   = swap_q;

  // R2
  line_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q <= LAST_LINE);
  // R5
  swap_vbl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_q |-> vbl_q && line_q == VBL_LINE);
  // R4
  hbl_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_i |=> !hbl_q);
  // R6
  vbl_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vbl_q) |-> line_q == LAST_LINE);
endmodule

// File: rtl/disp_cpu_regs.sv
module disp_cpu_regs
  import disp_pkg::*;
#(
  parameter int unsigned LINE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IRQ_W-1:0]  wr_irq_en_i,
  input  logic [LINE_W-1:0] wr_cmp_i,
  input  logic              hbl_evt_i,
  input  logic              vbl_evt_i,
  input  logic              adv_i,
  input  logic [LINE_W-1:0] line_next_i,
  output logic              match_o,
  output logic [IRQ_W-1:0]  irq_o
);
  logic [IRQ_W-1:0]  en_q;
  logic [LINE_W-1:0] cmp_q;
  logic              match_q;
  logic [IRQ_W-1:0]  irq_q;
  logic              hit;

  assign hit = (line_next_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      cmp_q   <= '0;
      match_q <= 1'b0;
      irq_q   <= '0;
    end else begin
      if (wr_en_i) begin
        en_q  <= wr_irq_en_i;
        cmp_q <= wr_cmp_i;
      end
      if (adv_i) match_q <= hit;
      irq_q[IRQ_VBL]   <= vbl_evt_i && en_q[IRQ_VBL];
      irq_q[IRQ_HBL]   <= hbl_evt_i && en_q[IRQ_HBL];
      irq_q[IRQ_MATCH] <= adv_i && hit && en_q[IRQ_MATCH];
    end
  end

  assign match_o = match_q;
  assign irq_o   = irq_q;

  // R7
  match_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q[IRQ_MATCH] |-> match_q);
  // R8
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q != '0) |=> (irq_q & $past(irq_q)) == '0);
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import disp_pkg::*;
#(
  parameter int unsigned ACTIVE_DOTS = 256,
  parameter int unsigned BLANK_DOTS  = 99,
  parameter int unsigned LINES       = 263,
  parameter int unsigned VIS_LINES   = 192,
  parameter int unsigned CYC_PER_DOT = 6,
  parameter int unsigned LINE_W      = 9,
  parameter int unsigned NUM_CPU     = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      dot_en_i,
  input  logic [NUM_CPU-1:0]        wr_en_i,
  input  logic [IRQ_W*NUM_CPU-1:0]  wr_irq_en_i,
  input  logic [LINE_W*NUM_CPU-1:0] wr_cmp_i,
  output logic                      hblank_o,
  output logic                      vblank_o,
  output logic [NUM_CPU-1:0]        match_o,
  output logic [LINE_W-1:0]         line_o,
  output logic                      swap_o,
  output logic [IRQ_W*NUM_CPU-1:0]  irq_o
);
  logic              hdraw_end, line_end, vbl_evt;
  logic [LINE_W-1:0] line_next;

  disp_dot_timer #(
    .ACTIVE_DOTS(ACTIVE_DOTS), .BLANK_DOTS(BLANK_DOTS), .CYC_PER_DOT(CYC_PER_DOT)
  ) u_dot (
    .clk_i(clk_i), .rst_ni(rst_ni), .dot_en_i(dot_en_i),
    .hdraw_end_o(hdraw_end), .line_end_o(line_end)
  );

  disp_line_ctr #(
    .LINES(LINES), .VIS_LINES(VIS_LINES), .LINE_W(LINE_W)
  ) u_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .hdraw_end_i(hdraw_end), .line_end_i(line_end),
    .line_o(line_o), .line_next_o(line_next), .vbl_evt_o(vbl_evt),
    .hblank_o(hblank_o), .vblank_o(vblank_o), .swap_o(swap_o)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    disp_cpu_regs #(.LINE_W(LINE_W)) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_en_i(wr_en_i[c]),
      .wr_irq_en_i(wr_irq_en_i[c*IRQ_W +: IRQ_W]),
      .wr_cmp_i(wr_cmp_i[c*LINE_W +: LINE_W]),
      .hbl_evt_i(hdraw_end), .vbl_evt_i(vbl_evt), .adv_i(line_end),
      .line_next_i(line_next),
      .match_o(match_o[c]),
      .irq_o(irq_o[c*IRQ_W +: IRQ_W])
    );

    // R3
    hbl_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c*IRQ_W + IRQ_HBL] |-> $rose(hblank_o));
    // R5
    vbl_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c*IRQ_W + IRQ_VBL] |-> swap_o && $rose(vblank_o));
  end
endmodule

// File: tb/disp_timing_gen_tb_top.sv
module disp_timing_gen_tb_top;
  localparam int ACT = 8, BLK = 5, LN = 12, VIS = 7, CPD = 2, LW = 9, NC = 2;
  localparam int TOT = ACT + BLK;

  logic clk = 1'b0, rst_n = 1'b0, dot_en = 1'b0;
  logic [NC-1:0]    wr_en = '0;
  logic [3*NC-1:0]  wr_irq = '0;
  logic [LW*NC-1:0] wr_cmp = '0;
  logic hbl, vbl, swp;
  logic [NC-1:0] mat;
  logic [LW-1:0] line;
  logic [3*NC-1:0] irq;

  always #10 clk = ~clk;

  disp_timing_gen #(.ACTIVE_DOTS(ACT), .BLANK_DOTS(BLK), .LINES(LN), .VIS_LINES(VIS),
    .CYC_PER_DOT(CPD), .LINE_W(LW), .NUM_CPU(NC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dot_en_i(dot_en), .wr_en_i(wr_en),
    .wr_irq_en_i(wr_irq), .wr_cmp_i(wr_cmp), .hblank_o(hbl), .vblank_o(vbl),
    .match_o(mat), .line_o(line), .swap_o(swp), .irq_o(irq));

  int checks = 0, fails = 0;

  // reference model built from the requirements
  int m_pre, m_dot, m_line;
  bit m_hb, m_vb, m_sw;
  bit [NC-1:0] m_mat;
  bit [2:0] m_en [NC];
  int m_cmp [NC];
  bit [2:0] m_irq [NC];

  function automatic int next_line(int l);
    return (l == LN - 1) ? 0 : l + 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_dot = 0; m_line = 0; m_hb = 0; m_vb = 0; m_sw = 0; m_mat = '0;
      for (int c = 0; c < NC; c++) begin m_en[c] = 0; m_cmp[c] = 0; m_irq[c] = 0; end
    end else begin
      bit tick, hend, lend;
      int nl;
      bit [2:0] old_en [NC];
      int old_cmp [NC];
      for (int c = 0; c < NC; c++) begin old_en[c] = m_en[c]; old_cmp[c] = m_cmp[c]; end
      tick = dot_en && (m_pre == CPD - 1);
      hend = tick && (m_dot == ACT - 1);
      lend = tick && (m_dot == TOT - 1);
      nl = next_line(m_line);
      m_sw = lend && (nl == VIS);
      for (int c = 0; c < NC; c++) begin
        m_irq[c][0] = m_sw && old_en[c][0];
        m_irq[c][1] = hend && old_en[c][1];
        m_irq[c][2] = lend && (nl == old_cmp[c]) && old_en[c][2];
        if (lend) m_mat[c] = (nl == old_cmp[c]);
        if (wr_en[c]) begin m_en[c] = wr_irq[3*c +: 3]; m_cmp[c] = int'(wr_cmp[LW*c +: LW]); end
      end
      if (hend) m_hb = 1;
      if (lend) begin
        m_line = nl; m_hb = 0;
        if (nl == VIS) m_vb = 1; else if (nl == LN - 1) m_vb = 0;
      end
      if (dot_en) begin
        m_pre = (m_pre == CPD - 1) ? 0 : m_pre + 1;
        if (tick) m_dot = (m_dot == TOT - 1) ? 0 : m_dot + 1;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2", "line", int'(line), m_line);
    chk("R3/R4", "hblank", int'(hbl), int'(m_hb));
    chk("R5/R6", "vblank", int'(vbl), int'(m_vb));
    chk("R5", "swap", int'(swp), int'(m_sw));
    for (int c = 0; c < NC; c++) begin
      chk("R7", "match", int'(mat[c]), int'(m_mat[c]));
      chk("R8", "irq", int'(irq[3*c +: 3]), int'(m_irq[c]));
    end
  endtask

  task automatic write_cfg(int c, bit [2:0] en, int cmp);
    wr_en[c] = 1'b1;
    wr_irq[3*c +: 3] = en;
    wr_cmp[LW*c +: LW] = LW'(cmp);
  endtask

  // one cycle: compare at negedge, then drive new inputs
  task automatic step(int en_pct, int wr_pct);
    @(negedge clk);
    compare_all();
    wr_en = '0;
    dot_en = ($urandom % 100) < en_pct;
    for (int c = 0; c < NC; c++)
      if (($urandom % 1000) < wr_pct)
        write_cfg(c, 3'($urandom), int'($urandom % LN));
  endtask

  bit done = 0;
  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin @(posedge clk); wd++; end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <150000", wd);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #35;
    // R10 reset state
    chk("R10", "line", int'(line), 0);
    chk("R10", "flags", int'({hbl, vbl, swp, mat}), 0);
    chk("R10", "irq", int'(irq), 0);
    rst_n = 1'b1;
    // R1 enable low: nothing moves
    for (int i = 0; i < 40; i++) step(0, 0);
    chk("R1", "line held", int'(line), 0);
    chk("R1", "hblank held", int'(hbl), 0);
    // R9 directed: copy 0 all enables, compare VIS; copy 1 compare 0, none
    @(negedge clk); compare_all();
    write_cfg(0, 3'b111, VIS); write_cfg(1, 3'b000, 0);
    for (int i = 0; i < 2 * CPD * TOT * LN; i++) step(100, 0);
    // directed compares: last line and line 0, copy 1 all enables
    @(negedge clk); compare_all(); wr_en = '0;
    write_cfg(0, 3'b100, LN - 1); write_cfg(1, 3'b111, 0);
    for (int i = 0; i < 2 * CPD * TOT * LN; i++) step(100, 0);
    // R9 write aligned with a line advance (full enable: advance every CPD*TOT cycles)
    @(negedge clk); wr_en = '0;
    while (!(m_dot == TOT - 1 && m_pre == CPD - 2)) step(100, 0);
    @(negedge clk); compare_all(); wr_en = '0; dot_en = 1'b1;
    write_cfg(0, 3'b100, next_line(m_line) + 1);
    for (int i = 0; i < 4 * CPD * TOT; i++) step(100, 0);
    // random mix with gapped enable and writes
    for (int i = 0; i < 20000; i++) step(70, 20);
    @(negedge clk); compare_all();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule